// File: doc/BRIEF.md
# I2C Interrupt Vector and Status Unit

This unit sits next to an I2C controller core and turns the core's single-cycle event pulses into state that software can see. Seven events are latched as pending bits: arbitration lost, no-acknowledge, register-access ready, receive data ready, transmit ready, stop detected and addressed-as-slave. A mask register selects which pending events drive the interrupt output, a status register shows a subset of the pending bits together with two live bus levels, and a vector register names one pending event by a 3-bit code.

Software services the unit by reading the vector register. Each read returns the code of the lowest-numbered pending event and clears that event, so a loop that reads until it sees zero drains every pending event. The access-ready and stop-detected events can also be cleared by writing one to their status bits. The register port is a plain single-cycle strobe interface: read data is combinational on the address while the read strobe is high, and side effects of a read or write take place at the next rising clock edge.

Top module: `i2c_evt_unit`

## Requirements
- R1: Event codes are fixed: arbitration lost 1, no-acknowledge 2, access ready 3, receive ready 4, transmit ready 5, stop detected 6, addressed-as-slave 7; the event input bit for code c is bit c-1 of `evt_i`.
- R2: The vector register (address 2) reads 0 whenever no event is pending.
- R3: A read strobe on the vector register clears the event it reports at the next clock edge; events that are neither pulsed nor cleared hold their pending state, so repeated reads return each pending event once and then 0.
- R4: With several events pending, the vector reports the one with the lowest nonzero code.
- R5: The mask register (address 0) holds one enable bit per event at position code-1 (bit 0 arbitration lost through bit 6 addressed-as-slave); bits 15:7 read as 0.
- R6: The status register (address 1) shows pending arbitration lost at bit 0, no-acknowledge at bit 1, access ready at bit 2, stop detected at bit 5, the live receive-shift-full input at bit 11 and the live bus-busy input at bit 12; all other bits read 0.
- R7: Writing 1 to status bit 2 or bit 5 clears the access-ready or stop-detected event; writing to status bits 0, 1, 11 or 12 has no effect on any state.
- R8: `irq_o` is high exactly when some pending event has its mask bit set.
- R9: An event pulse arriving in the same cycle as a clear of that event leaves the event pending.
- R10: After reset no event is pending, the mask is 0 and `irq_o` is low.
- R11: Addresses 3 to 7 read as 0, writes to the vector register change nothing, and reads of the mask or status register have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 7 | Single-cycle event pulses from the controller core, bit c-1 for code c |
| bus_busy_i | input | 1 | Live bus-busy level from the core |
| rx_shift_full_i | input | 1 | Live receive-shift-full level from the core |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address: 0 mask, 1 status, 2 vector |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data, valid while `rd_en_i` is high |
| irq_o | output | 1 | Interrupt output |

## Verification
The hardest situation to reach is an event pulse landing in the very cycle that a vector read is clearing the same event, because the read and the pulse must share one clock edge. The stimulus holds a pending arbitration-lost event, then drives the vector read strobe and a fresh arbitration-lost pulse together, and confirms through two further vector reads that the event survived exactly once. Draining every pattern from a table by repeated vector reads also shows that the priority order and the read-clear work together across mixed event sets.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

  localparam int NUM_EVT = 7;
  localparam int CODE_W  = 3;

  // event indices (bit position in pend / mask; code = index + 1)
  localparam int EV_ARB   = 0;
  localparam int EV_NACK  = 1;
  localparam int EV_ARDY  = 2;
  localparam int EV_RXRDY = 3;
  localparam int EV_TXRDY = 4;
  localparam int EV_STOP  = 5;
  localparam int EV_SLV   = 6;

  // status word bit positions
  localparam int SB_ARB   = 0;
  localparam int SB_NACK  = 1;
  localparam int SB_ARDY  = 2;
  localparam int SB_STOP  = 5;
  localparam int SB_RSF   = 11;
  localparam int SB_BUSY  = 12;

  // register addresses
  localparam int RA_MASK  = 0;
  localparam int RA_STAT  = 1;
  localparam int RA_VEC   = 2;

endpackage

// File: rtl/evt_pend.sv
module evt_pend #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q_r;
    logic q_nxt;
    logic q_en;

    always_comb begin
      q_en  = set_i[i] | clr_i[i];
      q_nxt = set_i[i];   // a set wins over a clear in the same cycle
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_r <= 1'b0;
      end else if (q_en) begin
        q_r <= q_nxt;
      end
    end

    assign pend_o[i] = q_r;

    // R9: a pulse always leaves the event pending, even against a clear
    assert_set_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> pend_o[i]);

    // R3: without pulse or clear the pending bit holds
    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i[i] && !clr_i[i]) |=> $stable(pend_o[i]));

    // R3: a clear without a pulse empties the bit
    assert_clear_works_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !pend_o[i]);
  end

endmodule

// File: rtl/evt_prio.sv
module evt_prio #(
  parameter int N  = 7,
  parameter int CW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic [CW-1:0] code_o,
  output logic [N-1:0]  sel_o
);

  always_comb begin
    code_o = '0;
    sel_o  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        code_o = CW'(k + 1);
        sel_o  = '0;
        sel_o[k] = 1'b1;
      end
    end
  end

  always_comb begin
    // R4: selection is at most one-hot and always among the requests
    assert_sel_onehot_R4: assert ($onehot0(sel_o));
    assert_sel_in_req_R4: assert ((sel_o & ~req_i) == '0);
  end

endmodule

// File: rtl/evt_regif.sv
module evt_regif
  import i2c_evt_pkg::*;
#(
  parameter int N  = 7,
  parameter int CW = 3,
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [N-1:0]  pend_i,
  input  logic [CW-1:0] vec_code_i,
  input  logic [N-1:0]  vec_sel_i,
  input  logic          bus_busy_i,
  input  logic          rx_shift_full_i,
  output logic [DW-1:0] rdata_o,
  output logic [N-1:0]  mask_o,
  output logic [N-1:0]  clr_o
);

  localparam logic [AW-1:0] A_MASK = AW'(RA_MASK);
  localparam logic [AW-1:0] A_STAT = AW'(RA_STAT);
  localparam logic [AW-1:0] A_VEC  = AW'(RA_VEC);

  logic          hit_mask;
  logic          hit_stat;
  logic          hit_vec;
  logic          mask_en;
  logic [N-1:0]  mask_r;
  logic [N-1:0]  mask_nxt;
  logic [N-1:0]  clr_rd;
  logic [N-1:0]  clr_w1c;
  logic [DW-1:0] stat_word;

  always_comb begin
    hit_mask = (addr_i == A_MASK);
    hit_stat = (addr_i == A_STAT);
    hit_vec  = (addr_i == A_VEC);
  end

  // mask register
  always_comb begin
    mask_en  = wr_en_i & hit_mask;
    mask_nxt = wdata_i[N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_r <= '0;
    end else if (mask_en) begin
      mask_r <= mask_nxt;
    end
  end

  assign mask_o = mask_r;

  // clear sources: vector read and write-one-to-clear
  always_comb begin
    clr_rd  = (rd_en_i && hit_vec) ? vec_sel_i : '0;
    clr_w1c = '0;
    if (wr_en_i && hit_stat) begin
      clr_w1c[EV_ARDY] = wdata_i[SB_ARDY];
      clr_w1c[EV_STOP] = wdata_i[SB_STOP];
    end
    clr_o = clr_rd | clr_w1c;
  end

  // status word
  always_comb begin
    stat_word          = '0;
    stat_word[SB_ARB]  = pend_i[EV_ARB];
    stat_word[SB_NACK] = pend_i[EV_NACK];
    stat_word[SB_ARDY] = pend_i[EV_ARDY];
    stat_word[SB_STOP] = pend_i[EV_STOP];
    stat_word[SB_RSF]  = rx_shift_full_i;
    stat_word[SB_BUSY] = bus_busy_i;
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (hit_mask)      rdata_o = DW'(mask_r);
      else if (hit_stat) rdata_o = stat_word;
      else if (hit_vec)  rdata_o = DW'(vec_code_i);
    end
  end

  // R11: mask changes only through a write to its address
  assert_mask_only_by_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && hit_mask) |=> $stable(mask_o));

  // R7: status writes never clear arbitration lost or no-acknowledge
  assert_w1c_limited_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && hit_stat) |-> (clr_o[EV_ARB] == 1'b0 && clr_o[EV_NACK] == 1'b0));

endmodule

// File: rtl/i2c_evt_unit.sv
module i2c_evt_unit
  import i2c_evt_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               bus_busy_i,
  input  logic               rx_shift_full_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               irq_o
);

  logic               rst_meta;
  logic               rst_sync_n;
  logic [NUM_EVT-1:0] pend;
  logic [NUM_EVT-1:0] clr;
  logic [NUM_EVT-1:0] mask;
  logic [NUM_EVT-1:0] vec_sel;
  logic [CODE_W-1:0]  vec_code;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  evt_pend #(.N(NUM_EVT)) u_pend (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (evt_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  evt_prio #(.N(NUM_EVT), .CW(CODE_W)) u_prio (
    .req_i  (pend),
    .code_o (vec_code),
    .sel_o  (vec_sel)
  );

  evt_regif #(.N(NUM_EVT), .CW(CODE_W), .AW(AW), .DW(DW)) u_regif (
    .clk             (clk),
    .rst_n           (rst_sync_n),
    .wr_en_i         (wr_en_i),
    .rd_en_i         (rd_en_i),
    .addr_i          (addr_i),
    .wdata_i         (wdata_i),
    .pend_i          (pend),
    .vec_code_i      (vec_code),
    .vec_sel_i       (vec_sel),
    .bus_busy_i      (bus_busy_i),
    .rx_shift_full_i (rx_shift_full_i),
    .rdata_o         (rdata_o),
    .mask_o          (mask),
    .clr_o           (clr)
  );

  always_comb begin
    irq_o = |(pend & mask);
  end

  // R2: zero code only when nothing is pending
  assert_vec_zero_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vec_code == '0) |-> (pend == '0));

  // R4: no pending event below the reported one
  assert_lowest_first_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vec_code != '0) |-> ((pend & (vec_sel - 1'b1)) == '0));

  // R3: a vector read removes the reported event unless it is re-pulsed
  assert_read_clear_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en_i && addr_i == AW'(RA_VEC) && vec_code != '0 && (evt_i & vec_sel) == '0)
      |=> ((pend & $past(vec_sel)) == '0));

  // R8: interrupt requires a pending, enabled event
  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o |-> ((pend & mask) != '0));

  // R6: busy bit follows the live input on a status read
  assert_busy_live_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en_i && addr_i == AW'(RA_STAT)) |-> (rdata_o[SB_BUSY] == bus_busy_i));

  // R10: reset leaves the interrupt low
  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_sync_n |-> !irq_o);

endmodule

// File: tb/i2c_evt_unit_tb_top.sv
`timescale 1ns/1ps
module i2c_evt_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic [6:0]  evt;
  logic        busy;
  logic        rsf;
  logic        wr;
  logic        rd;
  logic [2:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq;

  int n_chk;
  int n_bad;
  int cyc;

  i2c_evt_unit dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .evt_i           (evt),
    .bus_busy_i      (busy),
    .rx_shift_full_i (rsf),
    .wr_en_i         (wr),
    .rd_en_i         (rd),
    .addr_i          (addr),
    .wdata_i         (wdata),
    .rdata_o         (rdata),
    .irq_o           (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {pulses[6:0], mask[6:0], first code[2:0], irq}
  localparam int NROW = 8;
  localparam logic [17:0] TBL [NROW] = '{
    {7'b0000001, 7'h7F, 3'd1, 1'b1},
    {7'b0000010, 7'h00, 3'd2, 1'b0},
    {7'b1000000, 7'h40, 3'd7, 1'b1},
    {7'b0110000, 7'h0F, 3'd5, 1'b0},
    {7'b0101100, 7'h20, 3'd3, 1'b1},
    {7'b1111111, 7'h7F, 3'd1, 1'b1},
    {7'b0001000, 7'h08, 3'd4, 1'b1},
    {7'b0100000, 7'h1F, 3'd6, 1'b0}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog: actual hung, expected finished");
      summary();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [2:0] a, output logic [15:0] d,
                         input logic [6:0] p = 7'h00);
    @(negedge clk);
    rd = 1'b1; addr = a; evt = p;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0; evt = '0;
  endtask

  task automatic do_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] p);
    @(negedge clk);
    evt = p;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic drain(output int n);
    logic [15:0] d;
    n = 0;
    for (int k = 0; k < 16; k++) begin
      do_read(3'd2, d);
      if (d == 16'h0) break;
      n++;
    end
  endtask

  initial begin
    logic [15:0] d;
    int n;
    n_chk = 0; n_bad = 0; cyc = 0;
    evt = '0; busy = 1'b0; rsf = 1'b0; wr = 1'b0; rd = 1'b0;
    addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    #1 check("R10 irq", int'(irq), 0);
    do_read(3'd0, d); check("R10 mask", int'(d), 0);
    do_read(3'd2, d); check("R10/R2 vector", int'(d), 0);
    do_read(3'd1, d); check("R10 status", int'(d), 0);

    // R1 R4 R8 R3 table walk
    for (int r = 0; r < NROW; r++) begin
      logic [6:0] p;
      logic [6:0] m;
      p = TBL[r][17:11];
      m = TBL[r][10:4];
      drain(n);
      do_write(3'd0, {9'd0, m});
      pulse(p);
      #1 check($sformatf("R8 row %0d irq", r), int'(irq), int'(TBL[r][0]));
      do_read(3'd2, d);
      check($sformatf("R1/R4 row %0d code", r), int'(d), int'(TBL[r][3:1]));
      drain(n);
      check($sformatf("R3 row %0d drained", r), n + 1, $countones(p));
      #1 check($sformatf("R8 row %0d irq after drain", r), int'(irq), 0);
    end

    // R5 mask width and readback
    do_write(3'd0, 16'hFFFF);
    do_read(3'd0, d); check("R5 mask readback", int'(d), 16'h007F);
    do_write(3'd0, 16'h0000);

    // R6 live levels
    busy = 1'b1; rsf = 1'b1;
    do_read(3'd1, d); check("R6 live busy+rsf", int'(d), 16'h1800);
    busy = 1'b0;
    do_read(3'd1, d); check("R6 busy drop", int'(d), 16'h0800);
    rsf = 1'b0;

    // R6 R7 status and write-one-to-clear
    pulse(7'b0100111);
    do_read(3'd1, d); check("R6 status pending", int'(d), 16'h0027);
    do_write(3'd1, 16'h0024);
    do_read(3'd1, d); check("R7 w1c ardy/stop", int'(d), 16'h0003);
    do_write(3'd1, 16'h1803);
    do_read(3'd1, d); check("R7 ignored bits", int'(d), 16'h0003);
    drain(n); check("R7 remaining events", n, 2);

    // R9 pulse coinciding with read-clear
    pulse(7'b0000001);
    do_read(3'd2, d, 7'b0000001); check("R9 first read", int'(d), 1);
    do_read(3'd2, d); check("R9 still pending", int'(d), 1);
    do_read(3'd2, d); check("R9 then empty", int'(d), 0);

    // R11 address map and side-effect-free accesses
    pulse(7'b1000000);
    do_write(3'd2, 16'hFFFF);
    do_read(3'd1, d);
    do_read(3'd0, d);
    for (int a = 3; a < 8; a++) begin
      do_read(3'(a), d); check($sformatf("R11 addr %0d reads 0", a), int'(d), 0);
    end
    do_read(3'd2, d); check("R11 vector write ignored", int'(d), 7);
    do_read(3'd2, d); check("R11 drained", int'(d), 0);

    // R10 reset mid-run
    do_write(3'd0, 16'h007F);
    pulse(7'b0011000);
    #1 check("R8 irq before reset", int'(irq), 1);
    @(negedge clk); rst_n = 1'b0;
    #1 check("R10 irq in reset", int'(irq), 0);
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_read(3'd2, d); check("R10 vector after reset", int'(d), 0);
    do_read(3'd0, d); check("R10 mask after reset", int'(d), 0);

    summary();
  end

endmodule